// File: doc/BRIEF.md
# Two-Road Crossing Signal Sequencer

This block drives the signal lamps at a crossing of two roads, called road A and road B. Each road has a red, a yellow and a green lamp. A synchronous Moore machine steps through four lamp phases in a fixed ring. A down-counter times each phase, and every phase lasts for a build-time number of clock cycles. The machine holds a phase until that phase's own timer expires, and then it moves to the next phase in the ring.

The lamps are decoded only from the registered phase. They therefore never glitch in response to an input. A two-bit phase code is also brought out so the sequence can be observed. A synchronous reset restarts the ring at its first phase, whatever phase the machine is in, and that phase then runs for its full length.

Top module: `xroad_signal_ctrl`

## Requirements
- R1: On a rising clock edge with `rst` high, the phase becomes A-red/B-green (code 0). This holds from the cycle after that edge, for as long as `rst` stays high.
- R2: The phase codes advance only in the ring 0 → 1 → 2 → 3 → 0. The codes mean:
  - 0 = A-red/B-green
  - 1 = A-red/B-yellow
  - 2 = A-green/B-red
  - 3 = A-yellow/B-red
- R3: Each phase lasts exactly its configured number of cycles:
  - phase 0 lasts `GREEN_B_CYCLES`
  - phase 1 lasts `YELLOW_B_CYCLES`
  - phase 2 lasts `GREEN_A_CYCLES`
  - phase 3 lasts `YELLOW_A_CYCLES`
- R4: While the current phase's timer has not expired, the phase code and the lamps do not change.
- R5: On each road, exactly one of its three lamps is lit in every cycle.
- R6: At least one road shows red in every cycle, so the two roads are never green or yellow together.
- R7: A reset applied in the middle of any phase restarts phase 0 with its full duration.
- R8: The lamps match the phase code. The lamp vector `{aRed,aYellow,aGreen,bRed,bYellow,bGreen}` is:
  - 100001 for code 0
  - 100010 for code 1
  - 001100 for code 2
  - 010100 for code 3
- R9: A duration of 1 gives a phase that lasts one cycle. Durations that differ per phase are each honoured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| aRed | output | 1 | Road A red lamp |
| aYellow | output | 1 | Road A yellow lamp |
| aGreen | output | 1 | Road A green lamp |
| bRed | output | 1 | Road B red lamp |
| bYellow | output | 1 | Road B yellow lamp |
| bGreen | output | 1 | Road B green lamp |
| phaseCode | output | 2 | Current phase code, encoded as in R2 |

## Verification
The hardest case to reach from the ports is a phase that lasts a single cycle. In that case the timer must reload and expire in the same cycle as the phase change, and it must do so right after another short phase. The default durations never produce this. The bench therefore runs a second instance with unequal durations of 1, 2, 3 and 1 cycles next to the default one. Resets are dropped in at points chosen so that they land in the middle of green and yellow phases. A cycle model in the bench tracks phase and remaining time on every edge, and the bench measures the length of every phase.

// File: rtl/xroad_pkg.sv
package xroad_pkg;

  typedef enum logic [1:0] {
    PH_A_RED_B_GREEN  = 2'd0,
    PH_A_RED_B_YELLOW = 2'd1,
    PH_A_GREEN_B_RED  = 2'd2,
    PH_A_YELLOW_B_RED = 2'd3
  } phase_e;

  localparam int NUM_PHASES = 4;

  // strobes from the sequencer to the phase timer
  typedef struct packed {
    logic   loadTimer;
    phase_e loadPhase;
  } ctrlStrobe_t;

  function automatic phase_e ringNext(phase_e cur);
    logic [1:0] nxt;
    nxt = cur + 2'd1;
    return phase_e'(nxt);
  endfunction

endpackage

// File: rtl/xroad_phase_timer.sv
module xroad_phase_timer
  import xroad_pkg::*;
#(
  parameter int GREEN_A_CYCLES  = 8,
  parameter int YELLOW_A_CYCLES = 2,
  parameter int GREEN_B_CYCLES  = 8,
  parameter int YELLOW_B_CYCLES = 2,
  parameter int CNT_W           = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  ctrlStrobe_t strobe,
  output logic        timeout
);

  function automatic int phaseDur(int idx);
    case (idx)
      0:       return GREEN_B_CYCLES;
      1:       return YELLOW_B_CYCLES;
      2:       return GREEN_A_CYCLES;
      default: return YELLOW_A_CYCLES;
    endcase
  endfunction

  logic [CNT_W-1:0] loadTable [NUM_PHASES];
  logic [CNT_W-1:0] count;

  // reload value is duration minus one so that the zero cycle is the last one
  for (genvar i = 0; i < NUM_PHASES; i++) begin : g_load
    assign loadTable[i] = CNT_W'(phaseDur(i) - 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= loadTable[PH_A_RED_B_GREEN];
    end else if (strobe.loadTimer) begin
      count <= loadTable[strobe.loadPhase];
    end else begin
      count <= count - 1'b1;
    end
  end

  assign timeout = (count == '0);

endmodule

// File: rtl/xroad_seq_ctrl.sv
module xroad_seq_ctrl
  import xroad_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        timeout,
  output ctrlStrobe_t strobe,
  output phase_e      phase
);

  phase_e phaseNext;

  always_comb begin
    phaseNext = phase;
    if (timeout) begin
      phaseNext = ringNext(phase);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_A_RED_B_GREEN;
    end else begin
      phase <= phaseNext;
    end
  end

  always_comb begin
    strobe.loadTimer = timeout;
    strobe.loadPhase = ringNext(phase);
  end

endmodule

// File: rtl/xroad_lamp_decode.sv
module xroad_lamp_decode
  import xroad_pkg::*;
(
  input  phase_e phase,
  output logic   aRed,
  output logic   aYellow,
  output logic   aGreen,
  output logic   bRed,
  output logic   bYellow,
  output logic   bGreen
);

  always_comb begin
    {aRed, aYellow, aGreen, bRed, bYellow, bGreen} = 6'b100001;
    case (phase)
      PH_A_RED_B_GREEN:  {aRed, aYellow, aGreen, bRed, bYellow, bGreen} = 6'b100001;
      PH_A_RED_B_YELLOW: {aRed, aYellow, aGreen, bRed, bYellow, bGreen} = 6'b100010;
      PH_A_GREEN_B_RED:  {aRed, aYellow, aGreen, bRed, bYellow, bGreen} = 6'b001100;
      PH_A_YELLOW_B_RED: {aRed, aYellow, aGreen, bRed, bYellow, bGreen} = 6'b010100;
      default:           {aRed, aYellow, aGreen, bRed, bYellow, bGreen} = 6'b100100;
    endcase
  end

endmodule

// File: rtl/xroad_signal_ctrl.sv
module xroad_signal_ctrl
  import xroad_pkg::*;
#(
  parameter int GREEN_A_CYCLES  = 8,
  parameter int YELLOW_A_CYCLES = 2,
  parameter int GREEN_B_CYCLES  = 8,
  parameter int YELLOW_B_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rst,
  output logic       aRed,
  output logic       aYellow,
  output logic       aGreen,
  output logic       bRed,
  output logic       bYellow,
  output logic       bGreen,
  output logic [1:0] phaseCode
);

  localparam int MAX_AB  = (GREEN_A_CYCLES > YELLOW_A_CYCLES) ? GREEN_A_CYCLES : YELLOW_A_CYCLES;
  localparam int MAX_BB  = (GREEN_B_CYCLES > YELLOW_B_CYCLES) ? GREEN_B_CYCLES : YELLOW_B_CYCLES;
  localparam int MAX_DUR = (MAX_AB > MAX_BB) ? MAX_AB : MAX_BB;
  localparam int CNT_W   = (MAX_DUR > 1) ? $clog2(MAX_DUR) : 1;

  ctrlStrobe_t strobe;
  logic        timeout;
  phase_e      phase;

  xroad_seq_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .timeout (timeout),
    .strobe  (strobe),
    .phase   (phase)
  );

  xroad_phase_timer #(
    .GREEN_A_CYCLES  (GREEN_A_CYCLES),
    .YELLOW_A_CYCLES (YELLOW_A_CYCLES),
    .GREEN_B_CYCLES  (GREEN_B_CYCLES),
    .YELLOW_B_CYCLES (YELLOW_B_CYCLES),
    .CNT_W           (CNT_W)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .timeout (timeout)
  );

  xroad_lamp_decode u_lamps (
    .phase   (phase),
    .aRed    (aRed),
    .aYellow (aYellow),
    .aGreen  (aGreen),
    .bRed    (bRed),
    .bYellow (bYellow),
    .bGreen  (bGreen)
  );

  assign phaseCode = phase;

endmodule

// File: rtl/xroad_signal_chk.sv
module xroad_signal_chk #(
  parameter int GREEN_A_CYCLES  = 8,
  parameter int YELLOW_A_CYCLES = 2,
  parameter int GREEN_B_CYCLES  = 8,
  parameter int YELLOW_B_CYCLES = 2
) (
  input logic       clk,
  input logic       rst,
  input logic       aRed,
  input logic       aYellow,
  input logic       aGreen,
  input logic       bRed,
  input logic       bYellow,
  input logic       bGreen,
  input logic [1:0] phaseCode
);

  function automatic int unsigned durOf(logic [1:0] code);
    case (code)
      2'd0:    return GREEN_B_CYCLES;
      2'd1:    return YELLOW_B_CYCLES;
      2'd2:    return GREEN_A_CYCLES;
      default: return YELLOW_A_CYCLES;
    endcase
  endfunction

  logic [1:0]  lastCode;
  logic [1:0]  ringStep;
  int unsigned dwell;
  logic        rstSeen;
  logic [5:0]  lampVec;

  assign ringStep = lastCode + 2'd1;
  assign lampVec  = {aRed, aYellow, aGreen, bRed, bYellow, bGreen};

  // dwell = length of the run of phaseCode that ends in the cycle before this edge
  always_ff @(posedge clk) begin
    lastCode <= phaseCode;
    rstSeen  <= rst;
    if (rst) begin
      dwell <= 0;
    end else if (dwell == 0 || phaseCode != lastCode) begin
      dwell <= 1;
    end else begin
      dwell <= dwell + 1;
    end
  end

  // R1: the cycle after a reset edge is phase 0
  always @(posedge clk) begin
    if (rstSeen === 1'b1) begin
      assert_reset_start_R1 : assert (phaseCode == 2'd0 && aRed && bGreen);
    end
  end

  assert_ring_step_R2 : assert property (@(posedge clk) disable iff (rst)
    (dwell != 0 && phaseCode != lastCode) |-> (phaseCode == ringStep));

  assert_dwell_exact_R3 : assert property (@(posedge clk) disable iff (rst)
    (dwell != 0 && phaseCode != lastCode) |-> (dwell == durOf(lastCode)));

  assert_dwell_bound_R4 : assert property (@(posedge clk) disable iff (rst)
    (dwell != 0 && phaseCode == lastCode) |-> (dwell < durOf(phaseCode)));

  assert_one_lamp_a_R5 : assert property (@(posedge clk) disable iff (rst)
    $countones({aRed, aYellow, aGreen}) == 1);

  assert_one_lamp_b_R5 : assert property (@(posedge clk) disable iff (rst)
    $countones({bRed, bYellow, bGreen}) == 1);

  assert_cross_safe_R6 : assert property (@(posedge clk) disable iff (rst)
    (aRed || bRed));

  assert_code_map_R8 : assert property (@(posedge clk) disable iff (rst)
    (phaseCode == 2'd2) |-> (lampVec == 6'b001100));

endmodule

bind xroad_signal_ctrl xroad_signal_chk #(
  .GREEN_A_CYCLES  (GREEN_A_CYCLES),
  .YELLOW_A_CYCLES (YELLOW_A_CYCLES),
  .GREEN_B_CYCLES  (GREEN_B_CYCLES),
  .YELLOW_B_CYCLES (YELLOW_B_CYCLES)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .aRed      (aRed),
  .aYellow   (aYellow),
  .aGreen    (aGreen),
  .bRed      (bRed),
  .bYellow   (bYellow),
  .bGreen    (bGreen),
  .phaseCode (phaseCode)
);

// File: tb/xroad_signal_ctrl_tb_top.sv
`timescale 1ns/1ps
module xroad_signal_ctrl_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic       mAR, mAY, mAG, mBR, mBY, mBG;
  logic       sAR, sAY, sAG, sBR, sBY, sBG;
  logic [1:0] mCode, sCode;

  xroad_signal_ctrl dut_i (
    .clk(clk), .rst(rst),
    .aRed(mAR), .aYellow(mAY), .aGreen(mAG),
    .bRed(mBR), .bYellow(mBY), .bGreen(mBG),
    .phaseCode(mCode)
  );

  // short, unequal durations: phase0=1, phase1=2, phase2=3, phase3=1 (R9)
  xroad_signal_ctrl #(
    .GREEN_A_CYCLES(3), .YELLOW_A_CYCLES(1),
    .GREEN_B_CYCLES(1), .YELLOW_B_CYCLES(2)
  ) dut_min_i (
    .clk(clk), .rst(rst),
    .aRed(sAR), .aYellow(sAY), .aGreen(sAG),
    .bRed(sBR), .bYellow(sBY), .bGreen(sBG),
    .phaseCode(sCode)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int  refPhase [2];
  int  refLeft  [2];
  int  runLen   [2];
  int  prevObs  [2];
  bit  armed;
  bit  rstAtEdge;
  bit  ranSinceReset;

  function automatic int durOf(int inst, int ph);
    if (inst == 0) begin
      return (ph == 0 || ph == 2) ? 8 : 2;
    end
    case (ph)
      0:       return 1;
      1:       return 2;
      2:       return 3;
      default: return 1;
    endcase
  endfunction

  function automatic logic [5:0] lampsOf(int ph);
    case (ph)
      0:       return 6'b100001;
      1:       return 6'b100010;
      2:       return 6'b001100;
      default: return 6'b010100;
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: phase and cycles remaining in it
  always @(posedge clk) begin
    rstAtEdge = rst;
    if (rst) armed = 1;
    for (int k = 0; k < 2; k++) begin
      if (rst) begin
        refPhase[k] = 0;
        refLeft[k]  = durOf(k, 0);
      end else if (refLeft[k] == 1) begin
        refPhase[k] = (refPhase[k] + 1) % 4;
        refLeft[k]  = durOf(k, refPhase[k]);
      end else begin
        refLeft[k]  = refLeft[k] - 1;
      end
    end
  end

  task automatic compareOne(int k, logic [1:0] code, logic [5:0] lamps);
    check(int'(code) == refPhase[k], "R2 phase code vs model", int'(code), refPhase[k]);
    check(lamps == lampsOf(refPhase[k]), "R8 lamp pattern", int'(lamps), int'(lampsOf(refPhase[k])));
    check($countones(lamps[5:3]) == 1 && $countones(lamps[2:0]) == 1,
          "R5 one lamp per road", int'(lamps), 0);
    check(lamps[5] || lamps[2], "R6 a road is red", int'(lamps), 0);
    if (rstAtEdge) begin
      if (ranSinceReset)
        check(code == 2'd0, "R7 restart after mid-phase reset", int'(code), 0);
      else
        check(code == 2'd0, "R1 reset phase", int'(code), 0);
      runLen[k]  = 1;
      prevObs[k] = 0;
    end else begin
      if (int'(code) != prevObs[k]) begin
        check(runLen[k] == durOf(k, prevObs[k]),
              (k == 1) ? "R9 short phase length" : "R3 phase length",
              runLen[k], durOf(k, prevObs[k]));
        runLen[k] = 1;
      end else begin
        runLen[k] = runLen[k] + 1;
      end
      check(runLen[k] <= durOf(k, int'(code)), "R4 phase held within its time",
            runLen[k], durOf(k, int'(code)));
      prevObs[k] = int'(code);
    end
  endtask

  always @(negedge clk) begin
    if (armed && !done) begin
      compareOne(0, mCode, {mAR, mAY, mAG, mBR, mBY, mBG});
      compareOne(1, sCode, {sAR, sAY, sAG, sBR, sBY, sBG});
      if (rstAtEdge) ranSinceReset = 0; else ranSinceReset = 1;
    end
  end

  task automatic finishRun();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic runCycles(int n, bit r);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1 rst = r;
    end
  endtask

  initial begin
    rst = 1'b1;
    runCycles(3, 1'b1);
    runCycles(147, 1'b0);   // several full rings of both instances
    runCycles(1, 1'b1);     // single-cycle reset, mid-phase
    runCycles(37, 1'b0);
    runCycles(2, 1'b1);     // two-cycle reset, mid-phase
    runCycles(13, 1'b0);
    runCycles(1, 1'b1);
    runCycles(200, 1'b0);
    @(negedge clk);
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
      finishRun();
    end
  end

endmodule